// File: doc/BRIEF.md
# SPI Controller Register File with Transmit and Receive FIFOs

This block is the register front-end of a SPI master. A host reaches it through a simple read/write port with word-aligned offsets. It holds the setup fields for the serial engine, meaning clock rate and edges, word and data lengths, transfer format, frame-select polarity and timing, and FIFO thresholds, and it drives those fields straight out as configuration ports. The serial shifting is done by a separate engine, which is not part of this block.

One data offset serves both directions. A host write to that offset appends a word to an 8-entry transmit queue, which the engine drains through a valid/pop pair. A host read from the same offset takes the oldest word from an 8-entry receive queue, which the engine fills through a push strobe. Flushing a queue is a one-shot command in the FIFO control word. Three interrupt causes are held until the host clears them by writing 1: transmit threshold reached, receive threshold reached and receive overrun. The interrupt output is the OR of the enabled causes.

Top module: `spi_csr_fifo`

## Requirements
- R1: After reset every register reads 0 except status, which reads 0x20 (transmit not full). Both queues are empty, and `irq_o` and `tx_valid_o` are low.
- R2: Only the implemented fields are stored and read back, and all other bits read 0. They are: control bit 0 (enable) at 0x00; clock setup at 0x04, with divider 7:0, capture-on-falling bit 14, idle-high bit 13 and delay bit 12; transmit word setup at 0x08, with word length 13:8, format 7:6 and data length 5:0; receive word setup at 0x0C, with format 7:6 and data length 5:0; frame setup at 0x10, with polarity bit 15 and start-edge bit 14. Each field appears unchanged on its `cfg_*_o` port.
- R3: A write to 0x24 appends `reg_wdata_i` to the transmit queue. `tx_valid_o` is high while the queue holds a word, and `tx_data_o` shows the oldest word, or 0 when the queue is empty. `tx_pop_i` removes the oldest word. The queue holds 8 words, and a write while it is full is dropped.
- R4: A read of 0x24 returns the oldest received word and removes it. A read from an empty receive queue returns 0 and changes nothing.
- R5: Status at 0x14 has bit 7 (busy), which is set while the transmit queue is non-empty or `eng_busy_i` is high. Bit 5 is set while the transmit queue is not full, and bit 0 is set while the receive queue is not empty.
- R6: FIFO control at 0x20 stores the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. Writing 1 to bit 12 empties the transmit queue, and writing 1 to bit 4 empties the receive queue. The flush takes effect on the clock edge after the write, and a queue being flushed accepts no push or pop on that edge. The flush bits always read 0.
- R7: A `rx_push_i` while the receive queue holds 8 words drops the word and latches the overrun cause, which is bit 0 of 0x1C.
- R8: A transmit pop that leaves the queue count at or below the transmit threshold latches cause bit 4. An accepted receive push that brings the count to at least the receive threshold latches cause bit 3.
- R9: Reading 0x1C returns the pending causes in bits 4, 3 and 0. Writing 1 to one of those bits clears that cause, and writing 0 has no effect. A cause set on the same edge as its clear stays set.
- R10: Interrupt enable at 0x18 stores bits 4, 3 and 0. `irq_o` is high exactly when some pending cause has its enable bit set.
- R11: Offsets above 0x24 and any address with bits 1:0 not zero read 0 and ignore writes. `reg_rdata_o` is 0 whenever `reg_re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of `reg_re_i` |
| irq_o | output | 1 | Interrupt request |
| tx_valid_o | output | 1 | Transmit queue holds a word |
| tx_data_o | output | DATA_W | Oldest transmit word |
| tx_pop_i | input | 1 | Engine takes the oldest transmit word |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_data_i | input | DATA_W | Received word |
| eng_busy_i | input | 1 | Engine is shifting a word |
| cfg_en_o | output | 1 | Controller enable |
| cfg_clk_div_o | output | 8 | Serial clock divider |
| cfg_cap_fall_o | output | 1 | Capture on the falling edge |
| cfg_clk_idle_o | output | 1 | Serial clock idles high |
| cfg_clk_dly_o | output | 1 | Delayed first clock edge |
| cfg_tx_wlen_o | output | 6 | Transmit word length |
| cfg_tx_fmt_o | output | 2 | Transmit format |
| cfg_tx_dlen_o | output | 6 | Transmit data length |
| cfg_rx_fmt_o | output | 2 | Receive format |
| cfg_rx_dlen_o | output | 6 | Receive data length |
| cfg_fs_pol_o | output | 1 | Frame-select polarity |
| cfg_fs_start_o | output | 1 | Frame-select start edge |
| cfg_tx_thr_o | output | 4 | Transmit threshold |
| cfg_rx_thr_o | output | 4 | Receive threshold |

## Verification
A pointer or count that goes wrong inside a queue shows up as early as the next cycle. It appears on `tx_data_o`, in the status bits or in the word returned from 0x24. Because of this, the outputs are compared with a queue-based model on every clock, and not only at the end of a sequence. A wrong cause latch or a wrong flush timing reaches `irq_o` or the value read at 0x1C one edge after the event. The directed part of the test drives each queue through full, overrun, empty-read and flush. A random phase then mixes host accesses with engine pushes and pops, so that same-edge collisions between a flush, a push, a pop and a cause clear are exercised against the model.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_CAUSE = 3;

  // the word index selects the register; the order is the address map
  typedef enum logic [3:0] {
    SEL_CTL  = 4'd0,
    SEL_CKS  = 4'd1,
    SEL_TXW  = 4'd2,
    SEL_RXW  = 4'd3,
    SEL_FPS  = 4'd4,
    SEL_STAT = 4'd5,
    SEL_IEN  = 4'd6,
    SEL_ICLR = 4'd7,
    SEL_FCTL = 4'd8,
    SEL_DATA = 4'd9,
    SEL_NONE = 4'd15
  } reg_sel_e;

  localparam logic [REG_W-1:0] MSK_CTL = 32'h0000_0001;
  localparam logic [REG_W-1:0] MSK_CKS = 32'h0000_70FF;
  localparam logic [REG_W-1:0] MSK_TXW = 32'h0000_3FFF;
  localparam logic [REG_W-1:0] MSK_RXW = 32'h0000_00FF;
  localparam logic [REG_W-1:0] MSK_FPS = 32'h0000_C000;
  localparam logic [REG_W-1:0] MSK_IEN = 32'h0000_0019;
  localparam logic [REG_W-1:0] MSK_THR = 32'h0000_0F0F;

  localparam int unsigned FLUSH_TX_BIT = 12;
  localparam int unsigned FLUSH_RX_BIT = 4;

  // cause vector: [2] tx threshold, [1] rx threshold, [0] rx overrun
  function automatic logic [REG_W-1:0] cause_to_reg(input logic [NUM_CAUSE-1:0] c);
    logic [REG_W-1:0] r;
    r    = '0;
    r[4] = c[2];
    r[3] = c[1];
    r[0] = c[0];
    return r;
  endfunction

  function automatic logic [NUM_CAUSE-1:0] reg_to_cause(input logic [REG_W-1:0] r);
    return {r[4], r[3], r[0]};
  endfunction
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i & ~full_o & ~flush_i;
  assign pop_ok_o  = pop_i & ~empty_o & ~flush_i;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = flush_i ? '0 : cnt_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok_o);
  assign rdata_o   = empty_o ? '0 : mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] cause_o,
  output logic         irq_o
);
  logic [N-1:0] cause_q;

  for (genvar i = 0; i < N; i++) begin : g_cause
    // a set on the same edge as a clear wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q[i] <= 1'b0;
      else         cause_q[i] <= set_i[i] | (cause_q[i] & ~clr_i[i]);
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = |(cause_q & en_i);
endmodule

// File: rtl/spi_csr_fifo.sv
module spi_csr_fifo
  import spi_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_pop_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              eng_busy_i,
  output logic              cfg_en_o,
  output logic [7:0]        cfg_clk_div_o,
  output logic              cfg_cap_fall_o,
  output logic              cfg_clk_idle_o,
  output logic              cfg_clk_dly_o,
  output logic [5:0]        cfg_tx_wlen_o,
  output logic [1:0]        cfg_tx_fmt_o,
  output logic [5:0]        cfg_tx_dlen_o,
  output logic [1:0]        cfg_rx_fmt_o,
  output logic [5:0]        cfg_rx_dlen_o,
  output logic              cfg_fs_pol_o,
  output logic              cfg_fs_start_o,
  output logic [3:0]        cfg_tx_thr_o,
  output logic [3:0]        cfg_rx_thr_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = ADDR_W - 2;

  // ---------------- decode ----------------
  logic [IDX_W-1:0] widx;
  reg_sel_e         sel;

  assign widx = reg_addr_i[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr_i[1:0] == 2'b00 && widx <= IDX_W'(9)) sel = reg_sel_e'(widx[3:0]);
  end

  logic data_wr, data_rd, iclr_wr, fctl_wr;
  assign data_wr = reg_we_i && (sel == SEL_DATA);
  assign data_rd = reg_re_i && (sel == SEL_DATA);
  assign iclr_wr = reg_we_i && (sel == SEL_ICLR);
  assign fctl_wr = reg_we_i && (sel == SEL_FCTL);

  // ---------------- config registers ----------------
  logic [REG_W-1:0] ctl_q, cks_q, txw_q, rxw_q, fps_q, ien_q, thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cks_q <= '0;
      txw_q <= '0;
      rxw_q <= '0;
      fps_q <= '0;
      ien_q <= '0;
      thr_q <= '0;
    end else if (reg_we_i) begin
      unique case (sel)
        SEL_CTL:  ctl_q <= reg_wdata_i & MSK_CTL;
        SEL_CKS:  cks_q <= reg_wdata_i & MSK_CKS;
        SEL_TXW:  txw_q <= reg_wdata_i & MSK_TXW;
        SEL_RXW:  rxw_q <= reg_wdata_i & MSK_RXW;
        SEL_FPS:  fps_q <= reg_wdata_i & MSK_FPS;
        SEL_IEN:  ien_q <= reg_wdata_i & MSK_IEN;
        SEL_FCTL: thr_q <= reg_wdata_i & MSK_THR;
        default: ;
      endcase
    end
  end

  // flush commands act one edge after the write
  logic tx_flush_q, rx_flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= fctl_wr && reg_wdata_i[FLUSH_TX_BIT];
      rx_flush_q <= fctl_wr && reg_wdata_i[FLUSH_RX_BIT];
    end
  end

  // ---------------- queues ----------------
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0]  tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
  logic              tx_push_ok, tx_pop_ok, tx_full, tx_empty;
  logic              rx_push_ok, rx_pop_ok, rx_full, rx_empty;

  spi_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (tx_flush_q),
    .push_i    (data_wr),
    .wdata_i   (reg_wdata_i[DATA_W-1:0]),
    .pop_i     (tx_pop_i),
    .rdata_o   (tx_head),
    .cnt_o     (tx_cnt),
    .cnt_nxt_o (tx_cnt_nxt),
    .push_ok_o (tx_push_ok),
    .pop_ok_o  (tx_pop_ok),
    .full_o    (tx_full),
    .empty_o   (tx_empty)
  );

  spi_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (rx_flush_q),
    .push_i    (rx_push_i),
    .wdata_i   (rx_data_i),
    .pop_i     (data_rd),
    .rdata_o   (rx_head),
    .cnt_o     (rx_cnt),
    .cnt_nxt_o (rx_cnt_nxt),
    .push_ok_o (rx_push_ok),
    .pop_ok_o  (rx_pop_ok),
    .full_o    (rx_full),
    .empty_o   (rx_empty)
  );

  // ---------------- interrupt causes ----------------
  logic                 tx_thr_hit, rx_thr_hit, rx_ovr;
  logic [NUM_CAUSE-1:0] cause_set, cause_clr, cause_en, cause;

  assign tx_thr_hit = tx_pop_ok && (32'(tx_cnt_nxt) <= 32'(thr_q[11:8]));
  assign rx_thr_hit = rx_push_ok && (32'(rx_cnt_nxt) >= 32'(thr_q[3:0]));
  assign rx_ovr     = rx_push_i && rx_full;
  assign cause_set  = {tx_thr_hit, rx_thr_hit, rx_ovr};
  assign cause_clr  = iclr_wr ? reg_to_cause(reg_wdata_i) : '0;
  assign cause_en   = reg_to_cause(ien_q);

  spi_irq_ctl #(.N(NUM_CAUSE)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cause_set),
    .clr_i   (cause_clr),
    .en_i    (cause_en),
    .cause_o (cause),
    .irq_o   (irq_o)
  );

  // ---------------- read path ----------------
  logic             busy;
  logic [REG_W-1:0] stat_w, rd_mux;

  assign busy   = !tx_empty || eng_busy_i;
  assign stat_w = {24'b0, busy, 1'b0, !tx_full, 4'b0, !rx_empty};

  always_comb begin
    unique case (sel)
      SEL_CTL:  rd_mux = ctl_q;
      SEL_CKS:  rd_mux = cks_q;
      SEL_TXW:  rd_mux = txw_q;
      SEL_RXW:  rd_mux = rxw_q;
      SEL_FPS:  rd_mux = fps_q;
      SEL_STAT: rd_mux = stat_w;
      SEL_IEN:  rd_mux = ien_q;
      SEL_ICLR: rd_mux = cause_to_reg(cause);
      SEL_FCTL: rd_mux = thr_q;
      SEL_DATA: rd_mux = 32'(rx_head);
      default:  rd_mux = '0;
    endcase
  end

  assign reg_rdata_o = reg_re_i ? rd_mux : '0;

  // ---------------- engine side ----------------
  assign tx_valid_o     = !tx_empty;
  assign tx_data_o      = tx_head;
  assign cfg_en_o       = ctl_q[0];
  assign cfg_clk_div_o  = cks_q[7:0];
  assign cfg_cap_fall_o = cks_q[14];
  assign cfg_clk_idle_o = cks_q[13];
  assign cfg_clk_dly_o  = cks_q[12];
  assign cfg_tx_wlen_o  = txw_q[13:8];
  assign cfg_tx_fmt_o   = txw_q[7:6];
  assign cfg_tx_dlen_o  = txw_q[5:0];
  assign cfg_rx_fmt_o   = rxw_q[7:6];
  assign cfg_rx_dlen_o  = rxw_q[5:0];
  assign cfg_fs_pol_o   = fps_q[15];
  assign cfg_fs_start_o = fps_q[14];
  assign cfg_tx_thr_o   = thr_q[11:8];
  assign cfg_rx_thr_o   = thr_q[3:0];
endmodule

// File: rtl/spi_csr_fifo_chk.sv
module spi_csr_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic             tx_flush_i,
  input logic             rx_flush_i,
  input logic             data_wr_i,
  input logic             data_rd_i,
  input logic             tx_pop_i,
  input logic             rx_push_i,
  input logic [2:0]       cause_i,
  input logic             irq_o
);
  p_tx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CNT_W'(DEPTH));

  p_tx_full_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i == CNT_W'(DEPTH)) && data_wr_i && !tx_pop_i && !tx_flush_i
    |=> tx_cnt_i == CNT_W'(DEPTH));

  p_rx_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i == '0) && data_rd_i && !rx_push_i |=> rx_cnt_i == '0);

  p_tx_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_i |=> tx_cnt_i == '0);

  p_rx_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> rx_cnt_i == '0);

  p_overrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (rx_cnt_i == CNT_W'(DEPTH)) |=> cause_i[0]);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == '0) |-> !irq_o);
endmodule

bind spi_csr_fifo spi_csr_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_cnt_i   (tx_cnt),
  .rx_cnt_i   (rx_cnt),
  .tx_flush_i (tx_flush_q),
  .rx_flush_i (rx_flush_q),
  .data_wr_i  (data_wr),
  .data_rd_i  (data_rd),
  .tx_pop_i   (tx_pop_i),
  .rx_push_i  (rx_push_i),
  .cause_i    (cause),
  .irq_o      (irq_o)
);

// File: tb/spi_csr_fifo_bench.sv
module spi_csr_fifo_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni, we, re, tx_pop, rx_push, eng_busy;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [DW-1:0] rx_data, tx_data;
  logic          irq, tx_valid;
  logic          c_en, c_cf, c_ci, c_cd, c_fp, c_fs;
  logic [7:0]    c_div;
  logic [5:0]    c_twl, c_tdl, c_rdl;
  logic [1:0]    c_tf, c_rf;
  logic [3:0]    c_tt, c_rt;

  spi_csr_fifo #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_spi_csr_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_pop_i(tx_pop), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .eng_busy_i(eng_busy), .cfg_en_o(c_en), .cfg_clk_div_o(c_div), .cfg_cap_fall_o(c_cf),
    .cfg_clk_idle_o(c_ci), .cfg_clk_dly_o(c_cd), .cfg_tx_wlen_o(c_twl), .cfg_tx_fmt_o(c_tf),
    .cfg_tx_dlen_o(c_tdl), .cfg_rx_fmt_o(c_rf), .cfg_rx_dlen_o(c_rdl), .cfg_fs_pol_o(c_fp),
    .cfg_fs_start_o(c_fs), .cfg_tx_thr_o(c_tt), .cfg_rx_thr_o(c_rt)
  );

  int n_chk = 0;
  int n_err = 0;
  bit run = 1'b0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned txq[$];
  int unsigned rxq[$];
  bit [31:0] m_ctl, m_cks, m_txw, m_rxw, m_fps, m_ien, m_thr, m_cause;
  bit        m_ftx, m_frx;

  function automatic int widx_of(input logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return 99;
    return int'(a[AW-1:2]);
  endfunction

  function automatic bit [31:0] m_read(input logic [AW-1:0] a, input logic busy_in);
    case (widx_of(a))
      0: return m_ctl;
      1: return m_cks;
      2: return m_txw;
      3: return m_rxw;
      4: return m_fps;
      5: return {24'b0, (txq.size() > 0) || busy_in, 1'b0, txq.size() < DEPTH, 4'b0, rxq.size() > 0};
      6: return m_ien;
      7: return m_cause;
      8: return m_thr;
      9: return (rxq.size() > 0) ? rxq[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (widx_of(a))
      0, 1, 2, 3, 4: return "R2";
      5: return "R5";
      6: return "R10";
      7: return "R9";
      8: return "R6";
      9: return "R4";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin : mdl
    int  w;
    bit  tpop, tpush, rpop, rpush, tset, rset, ovr;
    bit [31:0] clr;
    if (!rst_ni) begin
      txq.delete(); rxq.delete();
      m_ctl = 0; m_cks = 0; m_txw = 0; m_rxw = 0; m_fps = 0; m_ien = 0; m_thr = 0;
      m_cause = 0; m_ftx = 0; m_frx = 0;
    end else begin
      w     = widx_of(addr);
      tpop  = tx_pop && txq.size() > 0 && !m_ftx;
      tpush = we && w == 9 && txq.size() < DEPTH && !m_ftx;
      rpop  = re && w == 9 && rxq.size() > 0 && !m_frx;
      rpush = rx_push && rxq.size() < DEPTH && !m_frx;
      ovr   = rx_push && rxq.size() == DEPTH;
      if (m_ftx) txq.delete();
      else begin
        if (tpop) void'(txq.pop_front());
        if (tpush) txq.push_back(wdata);
      end
      if (m_frx) rxq.delete();
      else begin
        if (rpop) void'(rxq.pop_front());
        if (rpush) rxq.push_back(rx_data);
      end
      tset = tpop && (txq.size() <= m_thr[11:8]);
      rset = rpush && (rxq.size() >= m_thr[3:0]);
      clr  = (we && w == 7) ? (wdata & 32'h19) : 32'd0;
      m_cause = (m_cause & ~clr) | {27'd0, tset, rset, 2'b00, ovr};
      m_ftx = we && w == 8 && wdata[12];
      m_frx = we && w == 8 && wdata[4];
      if (we) begin
        case (w)
          0: m_ctl = wdata & 32'h1;
          1: m_cks = wdata & 32'h70FF;
          2: m_txw = wdata & 32'h3FFF;
          3: m_rxw = wdata & 32'h00FF;
          4: m_fps = wdata & 32'hC000;
          6: m_ien = wdata & 32'h19;
          8: m_thr = wdata & 32'h0F0F;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (run && rst_ni) begin
      chk(tag_of(addr), rdata, re ? m_read(addr, eng_busy) : 32'd0);
      chk("R3", {tx_valid, tx_data}, {txq.size() > 0, (txq.size() > 0) ? txq[0] : 32'd0});
      chk("R10", irq, |(m_cause & m_ien));
      chk("R2", {c_en, c_div, c_cf, c_ci, c_cd, c_twl, c_tf, c_tdl, c_rf, c_rdl, c_fp, c_fs, c_tt, c_rt},
          {m_ctl[0], m_cks[7:0], m_cks[14], m_cks[13], m_cks[12], m_txw[13:8], m_txw[7:6],
           m_txw[5:0], m_rxw[7:6], m_rxw[5:0], m_fps[15], m_fps[14], m_thr[11:8], m_thr[3:0]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string r);
    re = 1'b1; addr = a;
    @(negedge clk);
    chk(r, rdata, exp);
    cyc();
    re = 1'b0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    rx_push = 1'b1; rx_data = d;
    cyc();
    rx_push = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; we = 0; re = 0; addr = 0; wdata = 0;
    tx_pop = 0; rx_push = 0; rx_data = 0; eng_busy = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    run = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", {irq, tx_valid}, 2'b00);
    cyc();
    rd_expect(8'h14, 32'h20, "R1");
    rd_expect(8'h08, 32'h0, "R1");

    // R2 field masks
    wr(8'h00, 32'hFFFF_FFFF); rd_expect(8'h00, 32'h1, "R2");
    wr(8'h04, 32'hFFFF_FFFF); rd_expect(8'h04, 32'h70FF, "R2");
    wr(8'h08, 32'hFFFF_FFFF); rd_expect(8'h08, 32'h3FFF, "R2");
    wr(8'h0C, 32'hFFFF_FFFF); rd_expect(8'h0C, 32'h00FF, "R2");
    wr(8'h10, 32'hFFFF_FFFF); rd_expect(8'h10, 32'hC000, "R2");

    // R3 fill past depth; ninth write dropped
    for (int i = 0; i < 9; i++) wr(8'h24, 32'h100 + i);
    rd_expect(8'h14, 32'h80, "R5");
    for (int i = 0; i < 8; i++) begin
      tx_pop = 1'b1;
      @(negedge clk);
      chk("R3", tx_data, 32'h100 + i);
      cyc();
    end
    tx_pop = 1'b0;
    @(negedge clk);
    chk("R3", tx_valid, 1'b0);
    cyc();
    rd_expect(8'h1C, 32'h10, "R8");

    // R7 overrun on ninth engine word
    for (int i = 0; i < 9; i++) eng_push(32'hA0 + i);
    rd_expect(8'h1C, 32'h19, "R7");
    rd_expect(8'h14, 32'h21, "R5");
    eng_busy = 1'b1;
    rd_expect(8'h14, 32'hA1, "R5");
    eng_busy = 1'b0;

    // R4 order and empty read
    for (int i = 0; i < 8; i++) rd_expect(8'h24, 32'hA0 + i, "R4");
    rd_expect(8'h24, 32'h0, "R4");
    rd_expect(8'h14, 32'h20, "R4");

    // R9 write-one-to-clear
    wr(8'h1C, 32'h08); rd_expect(8'h1C, 32'h11, "R9");
    wr(8'h1C, 32'h00); rd_expect(8'h1C, 32'h11, "R9");
    wr(8'h1C, 32'hFFFF_FFFF); rd_expect(8'h1C, 32'h00, "R9");

    // R10 enable mask and irq
    wr(8'h18, 32'hFFFF_FFFF); rd_expect(8'h18, 32'h19, "R10");
    @(negedge clk); chk("R10", irq, 1'b0); cyc();
    eng_push(32'h55);
    @(negedge clk); chk("R10", irq, 1'b1); cyc();
    wr(8'h1C, 32'h19);
    @(negedge clk); chk("R10", irq, 1'b0); cyc();
    rd_expect(8'h24, 32'h55, "R4");

    // R8 thresholds: tx 2, rx 3
    wr(8'h20, 32'h0203);
    eng_push(32'h1); eng_push(32'h2);
    rd_expect(8'h1C, 32'h00, "R8");
    eng_push(32'h3);
    rd_expect(8'h1C, 32'h08, "R8");
    wr(8'h1C, 32'h19);

    // R6 flush
    for (int i = 0; i < 3; i++) wr(8'h24, 32'h200 + i);
    wr(8'h20, 32'h1203);
    rd_expect(8'h20, 32'h0203, "R6");
    rd_expect(8'h14, 32'h21, "R6");
    wr(8'h20, 32'h0213);
    cyc();
    rd_expect(8'h14, 32'h20, "R6");
    rd_expect(8'h24, 32'h0, "R6");

    // R11 unmapped and misaligned
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0);
    rd_expect(8'h28, 32'h0, "R11");
    rd_expect(8'h3C, 32'h0, "R11");
    rd_expect(8'h01, 32'h0, "R11");
    rd_expect(8'h00, 32'h1, "R11");
    @(negedge clk); chk("R11", rdata, 32'h0); cyc();

    // random mix compared against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      we       = ($urandom_range(0, 2) == 0);
      re       = ($urandom_range(0, 2) == 0);
      addr     = ($urandom_range(0, 2) == 0) ? 8'h24 : {2'b00, 4'($urandom_range(0, 15)), 2'b00};
      if ($urandom_range(0, 15) == 0) addr[1:0] = 2'($urandom_range(1, 3));
      wdata    = $urandom;
      if (addr == 8'h20 && $urandom_range(0, 3) != 0) wdata[12] = 1'b0;
      if (addr == 8'h20 && $urandom_range(0, 3) != 0) wdata[4] = 1'b0;
      tx_pop   = ($urandom_range(0, 3) == 0);
      rx_push  = ($urandom_range(0, 2) == 0);
      rx_data  = $urandom;
      eng_busy = ($urandom_range(0, 3) == 0);
      cyc();
    end
    we = 0; re = 0; tx_pop = 0; rx_push = 0; eng_busy = 0;
    repeat (2) cyc();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule